// File: doc/BRIEF.md
# Multicycle Processor Controller with Exception Trapping

This block is the control state machine of a multicycle load/store processor. It steps every instruction through fetch, decode and a short execute path chosen by the opcode, and it drives the select lines and write strobes of the datapath. The datapath holds the ALU, register file, memory, the exception address register (EPC) and the cause register.

Two exceptions are trapped. An opcode or R-type function code the controller does not know sends it from decode into an undefined-instruction trap state. A signed overflow on add, subtract or add-immediate is noted during the execute state. The result is still written back, and the controller then enters an overflow trap state. Both trap states use the ALU to form PC minus 4 (the address of the faulting instruction) and load it into the EPC. They load a one-bit cause code and send the PC to a fixed handler address. Fetch then resumes from that address.

Top module: `mc_trap_ctrl`

## Requirements
- R1: While `rst` is high the state machine is forced to fetch and every write strobe (`pc_wr_u`, `pc_wr_c`, `pc_load`, `reg_wr`, `ir_wr`, `mem_wr`, `epc_wr`, `cause_wr`) is 0. The first cycle after `rst` falls is a fetch cycle.
- R2: Fetch drives `alu_src_a`=0 (PC), `alu_src_b`=01 (constant 4), `alu_op`=00 (add), `pc_wr_u`=1, `pc_src`=00 (ALU result) and `ir_wr`=1. Decode drives `alu_src_a`=0, `alu_src_b`=11 (shifted immediate) and `alu_op`=00, with no strobe.
- R3: Load (opcode 100011) takes address (`alu_src_a`=1, `alu_src_b`=10, `alu_op`=00), read (`mem_data_addr`=1) and write-back (`reg_wr`=1, `reg_src`=01) states. Store (101011) takes the address state and then a write state (`mem_wr`=1, `mem_data_addr`=1).
- R4: R-type (opcode 000000) with a known function code takes an execute state (`alu_src_a`=1, `alu_src_b`=00, `alu_op`=10, meaning decode the function field) and then a write-back state (`reg_wr`=1, `reg_src`=00). The known function codes are add 100000, sub 100010, and 100100, or 100101 and slt 101010.
- R5: Add-immediate (001000) takes an execute state (`alu_src_a`=1, `alu_src_b`=10, `alu_op`=00) and then a write-back state (`reg_wr`=1, `reg_src`=10).
- R6: Branch-equal (000100) takes one state with `alu_src_a`=1, `alu_src_b`=00, `alu_op`=01 (subtract), `pc_wr_c`=1 and `pc_src`=01. Jump (000010) takes one state with `pc_wr_u`=1 and `pc_src`=10. In both cases fetch follows.
- R7: In every state `pc_load` equals `pc_wr_u` OR (`pc_wr_c` AND `alu_zero`).
- R8: Any other opcode, and any R-type function code outside the list in R4, goes from decode straight into the undefined-instruction trap with `cause_val`=0.
- R9: If `alu_ovf` is high during the execute state of add, sub or add-immediate, the write-back state still occurs with `reg_wr`=1. The overflow trap with `cause_val`=1 follows.
- R10: `alu_ovf` has no effect for any other instruction or in any other state. Those instructions end in fetch without a trap.
- R11: Each trap state lasts one cycle and drives `alu_src_a`=0, `alu_src_b`=01, `alu_op`=01, `epc_wr`=1, `cause_wr`=1, `pc_wr_u`=1, `pc_wr_c`=0 and `pc_src`=11. Fetch follows.
- R12: `trap_vec`, the fourth PC source, carries the handler address 32'hC000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| alu_ovf | input | 1 | ALU signed-overflow flag |
| alu_zero | input | 1 | ALU zero flag |
| alu_src_a | output | 1 | ALU first operand: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU second operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | 00 add, 01 subtract, 10 decode function field |
| pc_wr_u | output | 1 | Unconditional PC write |
| pc_wr_c | output | 1 | PC write conditional on zero |
| pc_load | output | 1 | Combined PC load enable |
| pc_src | output | 2 | PC source: 00 ALU, 01 branch target, 10 jump target, 11 trap vector |
| reg_wr | output | 1 | Register file write |
| reg_src | output | 2 | Write-back select: 00 ALU to rd, 01 memory to rt, 10 ALU to rt |
| ir_wr | output | 1 | Instruction register load |
| mem_wr | output | 1 | Data memory write |
| mem_data_addr | output | 1 | Memory address from ALU output register rather than PC |
| epc_wr | output | 1 | EPC load strobe |
| cause_wr | output | 1 | Cause register load strobe |
| cause_val | output | 1 | Cause code: 0 undefined instruction, 1 overflow |
| trap_vec | output | 32 | Handler address for PC source 11 |

## Verification
The hardest case to reach from the ports is the overflow trap. The flag must be seen in the execute state of a checked instruction and remembered past a write-back state in which the ALU no longer reports it. The bench sweeps every opcode, and every function code under the R-type opcode, with each combination of overflow and zero flags held for the whole instruction. Each add, sub and add-immediate therefore runs with and without overflow. Every other instruction sees a raised flag in all of its states and must not trap. A reset is also applied in the middle of a load.

// File: rtl/mc_trap_ctrl.sv
module mc_trap_ctrl #(
  parameter logic [31:0] TRAP_ADDR = 32'hC000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  input  logic        alu_ovf,
  input  logic        alu_zero,
  output logic        alu_src_a,
  output logic [1:0]  alu_src_b,
  output logic [1:0]  alu_op,
  output logic        pc_wr_u,
  output logic        pc_wr_c,
  output logic        pc_load,
  output logic [1:0]  pc_src,
  output logic        reg_wr,
  output logic [1:0]  reg_src,
  output logic        ir_wr,
  output logic        mem_wr,
  output logic        mem_data_addr,
  output logic        epc_wr,
  output logic        cause_wr,
  output logic        cause_val,
  output logic [31:0] trap_vec
);
  localparam logic [5:0] OP_RT = 6'b000000, OP_LW = 6'b100011, OP_SW = 6'b101011,
                         OP_BEQ = 6'b000100, OP_J = 6'b000010, OP_ADDI = 6'b001000;
  localparam logic [5:0] FN_ADD = 6'b100000, FN_SUB = 6'b100010, FN_AND = 6'b100100,
                         FN_OR = 6'b100101, FN_SLT = 6'b101010;

  typedef enum logic [3:0] {
    S_FETCH, S_DEC, S_MADR, S_MRD, S_LDWB, S_MWR, S_REX, S_RWB,
    S_IEX, S_IWB, S_BEQ, S_JMP, S_TUND, S_TOVF
  } state_t;

  state_t state, nxt;
  logic   ovf_q;
  logic   fn_chk, fn_ok;
  logic   pcu, pcc, rw, irw, mw, ew, cw;

  assign fn_chk = (funct == FN_ADD) || (funct == FN_SUB);
  assign fn_ok  = fn_chk || (funct == FN_AND) || (funct == FN_OR) || (funct == FN_SLT);
  assign trap_vec = TRAP_ADDR;

  always_comb begin
    nxt = S_FETCH;
    unique case (state)
      S_FETCH: nxt = S_DEC;
      S_DEC: begin
        unique case (opcode)
          OP_LW, OP_SW: nxt = S_MADR;
          OP_RT:        nxt = fn_ok ? S_REX : S_TUND;
          OP_ADDI:      nxt = S_IEX;
          OP_BEQ:       nxt = S_BEQ;
          OP_J:         nxt = S_JMP;
          default:      nxt = S_TUND;
        endcase
      end
      S_MADR: nxt = (opcode == OP_LW) ? S_MRD : S_MWR;
      S_MRD:  nxt = S_LDWB;
      S_REX:  nxt = S_RWB;
      S_IEX:  nxt = S_IWB;
      S_RWB, S_IWB: nxt = ovf_q ? S_TOVF : S_FETCH;
      default: nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      ovf_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_REX)      ovf_q <= alu_ovf && fn_chk;
      else if (state == S_IEX) ovf_q <= alu_ovf;
      else if (state == S_FETCH) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    alu_src_a = 1'b0; alu_src_b = 2'b00; alu_op = 2'b00;
    pcu = 1'b0; pcc = 1'b0; pc_src = 2'b00;
    rw = 1'b0; reg_src = 2'b00; irw = 1'b0; mw = 1'b0; mem_data_addr = 1'b0;
    ew = 1'b0; cw = 1'b0; cause_val = 1'b0;
    unique case (state)
      S_FETCH: begin alu_src_b = 2'b01; pcu = 1'b1; irw = 1'b1; end
      S_DEC:   alu_src_b = 2'b11;
      S_MADR, S_IEX: begin alu_src_a = 1'b1; alu_src_b = 2'b10; end
      S_MRD:   mem_data_addr = 1'b1;
      S_LDWB:  begin rw = 1'b1; reg_src = 2'b01; end
      S_MWR:   begin mw = 1'b1; mem_data_addr = 1'b1; end
      S_REX:   begin alu_src_a = 1'b1; alu_op = 2'b10; end
      S_RWB:   rw = 1'b1;
      S_IWB:   begin rw = 1'b1; reg_src = 2'b10; end
      S_BEQ:   begin alu_src_a = 1'b1; alu_op = 2'b01; pcc = 1'b1; pc_src = 2'b01; end
      S_JMP:   begin pcu = 1'b1; pc_src = 2'b10; end
      S_TUND, S_TOVF: begin
        alu_src_b = 2'b01; alu_op = 2'b01; pcu = 1'b1; pc_src = 2'b11;
        ew = 1'b1; cw = 1'b1; cause_val = (state == S_TOVF);
      end
      default: ;
    endcase
  end

  assign pc_wr_u  = pcu & ~rst;
  assign pc_wr_c  = pcc & ~rst;
  assign pc_load  = (pcu | (pcc & alu_zero)) & ~rst;
  assign reg_wr   = rw  & ~rst;
  assign ir_wr    = irw & ~rst;
  assign mem_wr   = mw  & ~rst;
  assign epc_wr   = ew  & ~rst;
  assign cause_wr = cw  & ~rst;

  a_r1_fetch_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ir_wr && pc_wr_u));

  a_r11_trap_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cause_wr |=> (ir_wr && !cause_wr));

  a_r11_trap_controls: assert property (@(posedge clk) disable iff (rst)
    cause_wr |-> (epc_wr && pc_wr_u && !pc_wr_c && pc_src == 2'b11 && alu_op == 2'b01
                  && alu_src_b == 2'b01 && !alu_src_a));

  a_r9_wb_then_trap: assert property (@(posedge clk) disable iff (rst)
    (state == S_REX && alu_ovf && fn_chk) |=> reg_wr ##1 (cause_wr && cause_val));

  a_r9_ovf_needs_wb: assert property (@(posedge clk) disable iff (rst)
    (cause_wr && cause_val) |-> $past(reg_wr));

  a_r8_undef_from_decode: assert property (@(posedge clk) disable iff (rst)
    (cause_wr && !cause_val) |-> $past(state == S_DEC));

  a_r7_one_pc_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_wr_u, pc_wr_c}));
endmodule

// File: tb/mc_trap_ctrl_bench.sv
`timescale 1ns/1ps
module mc_trap_ctrl_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] opcode = '0, funct = '0;
  logic alu_ovf = 1'b0, alu_zero = 1'b0;
  logic alu_src_a, pc_wr_u, pc_wr_c, pc_load, reg_wr, ir_wr, mem_wr, mem_data_addr;
  logic epc_wr, cause_wr, cause_val;
  logic [1:0] alu_src_b, alu_op, pc_src, reg_src;
  logic [31:0] trap_vec;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mc_trap_ctrl u_mc_trap_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .alu_ovf(alu_ovf),
    .alu_zero(alu_zero), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
    .pc_wr_u(pc_wr_u), .pc_wr_c(pc_wr_c), .pc_load(pc_load), .pc_src(pc_src),
    .reg_wr(reg_wr), .reg_src(reg_src), .ir_wr(ir_wr), .mem_wr(mem_wr),
    .mem_data_addr(mem_data_addr), .epc_wr(epc_wr), .cause_wr(cause_wr),
    .cause_val(cause_val), .trap_vec(trap_vec));

  wire [18:0] got = {alu_src_a, alu_src_b, alu_op, pc_wr_u, pc_wr_c, pc_load, pc_src,
                     reg_wr, reg_src, ir_wr, mem_wr, mem_data_addr, epc_wr, cause_wr, cause_val};
  wire [7:0] strobes = {pc_wr_u, pc_wr_c, pc_load, reg_wr, ir_wr, mem_wr, epc_wr, cause_wr};

  // phase ids: 0 fetch,1 decode,2 addr,3 read,4 load wb,5 store,6 r-ex,7 r-wb,
  // 8 addi-ex,9 addi-wb,10 beq,11 jump,12 undef trap,13 ovf trap
  function automatic logic [18:0] expect_of(int ph, logic z);
    logic a; logic [1:0] b, op, ps, rs; logic u, c, rw, iw, mw, md, ew, cw, cv;
    a = 0; b = 0; op = 0; u = 0; c = 0; ps = 0; rw = 0; rs = 0; iw = 0; mw = 0; md = 0;
    ew = 0; cw = 0; cv = 0;
    case (ph)
      0: begin b = 2'b01; u = 1; iw = 1; end                         // R2
      1: b = 2'b11;                                                  // R2
      2, 8: begin a = 1; b = 2'b10; end                              // R3 R5
      3: md = 1;                                                     // R3
      4: begin rw = 1; rs = 2'b01; end                               // R3
      5: begin mw = 1; md = 1; end                                   // R3
      6: begin a = 1; op = 2'b10; end                                // R4
      7: rw = 1;                                                     // R4
      9: begin rw = 1; rs = 2'b10; end                               // R5
      10: begin a = 1; op = 2'b01; c = 1; ps = 2'b01; end            // R6
      11: begin u = 1; ps = 2'b10; end                               // R6
      default: begin b = 2'b01; op = 2'b01; u = 1; ps = 2'b11; ew = 1; cw = 1;
                     cv = (ph == 13); end                            // R11
    endcase
    return {a, b, op, u, c, u | (c & z), ps, rw, rs, iw, mw, md, ew, cw, cv}; // R7
  endfunction

  function automatic string req_of(int ph);
    case (ph)
      0, 1: return "R2";
      2, 3, 4, 5: return "R3";
      6, 7: return "R4";
      8, 9: return "R5";
      10, 11: return "R6";
      12: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge with the design in fetch; returns at a negedge in fetch
  task automatic run_instr(logic [5:0] op, logic [5:0] fn, logic ov, logic z);
    int seq[6]; int n;
    bit chk;
    opcode = op; funct = fn; alu_ovf = ov; alu_zero = z;
    seq[0] = 0; seq[1] = 1; n = 3;
    chk = 0;
    case (op)
      6'b100011: begin seq[2] = 2; seq[3] = 3; seq[4] = 4; n = 5; end
      6'b101011: begin seq[2] = 2; seq[3] = 5; n = 4; end
      6'b001000: begin seq[2] = 8; seq[3] = 9; n = 4; chk = 1; end
      6'b000100: seq[2] = 10;
      6'b000010: seq[2] = 11;
      6'b000000: begin
        if (fn == 6'b100000 || fn == 6'b100010) begin seq[2] = 6; seq[3] = 7; n = 4; chk = 1; end
        else if (fn == 6'b100100 || fn == 6'b100101 || fn == 6'b101010) begin
          seq[2] = 6; seq[3] = 7; n = 4; end
        else seq[2] = 12;
      end
      default: seq[2] = 12;
    endcase
    if (chk && ov) begin seq[n] = 13; n++; end  // R9; otherwise R10: no trap
    for (int k = 0; k < n; k++) begin
      #1;
      check(got == expect_of(seq[k], z), (k >= 2 && !chk && ov && seq[k] != 12) ? "R10" :
            req_of(seq[k]), 32'(got), 32'(expect_of(seq[k], z)));
      @(negedge clk);
    end
  endtask

  initial begin
    @(negedge clk);
    #1 check(strobes == 8'h00, "R1", 32'(strobes), 32'h0);
    @(negedge clk);
    #1 check(strobes == 8'h00, "R1", 32'(strobes), 32'h0);
    check(trap_vec == 32'hC000_0000, "R12", trap_vec, 32'hC000_0000);
    rst = 1'b0;
    run_instr(6'b100011, 6'b0, 1'b0, 1'b0);
    // R1: reset in the middle of a load
    opcode = 6'b100011;
    @(negedge clk); @(negedge clk);
    rst = 1'b1;
    #1 check(strobes == 8'h00, "R1", 32'(strobes), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    #1 check(got == expect_of(0, 1'b0), "R1", 32'(got), 32'(expect_of(0, 1'b0)));
    #1;
    for (int op = 0; op < 64; op++)
      for (int oz = 0; oz < 4; oz++)
        run_instr(6'(op), 6'b100000, oz[1], oz[0]);
    for (int fn = 0; fn < 64; fn++)
      for (int oz = 0; oz < 4; oz++)
        run_instr(6'b000000, 6'(fn), oz[1], oz[0]);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule